// File: doc/BRIEF.md
# Keyboard Strobe Handshake Port

This block accepts one byte at a time from a parallel character source, such as a keyboard or a second computer, and presents it to a processor bus. The source places an 8-bit positive-logic character on the data inputs and pulls an active-low strobe. The port synchronizes the strobe and captures the byte on the strobe's falling edge. It then sets a data-ready flag and pulls its active-low interrupt output low.

When the processor reads the data port, the interrupt is released. The same read launches an active-low acknowledge pulse one bus cycle long, so that a sending computer can pace its transfers: it keeps the data steady until it has seen that pulse. A second read port returns status. Status bit 0 is data-ready. Status bit 1 is a sticky overrun flag, which is set when a new byte replaces one that was never read.

All state advances only on clock edges where the bus enable is high. The block therefore runs at the processor's bus rate while sharing a faster system clock.

Top module: `kbd_strobe_port`

## Requirements
- R1: After reset, irqN and ackN are high, rxData is 0 and rxStatus is 0.
- R2: A falling edge of keyStrobeN captures keyData into rxData on the third enabled clock edge after the fall. On that same edge rxStatus bit 0 (ready) becomes 1 and irqN goes low.
- R3: A strobe held low captures only once. Changes to keyData while it stays low leave rxData and ready unchanged until the strobe returns high and falls again.
- R4: A data read (rdData high on an enabled edge) clears ready and returns irqN high on that edge.
- R5: Every data read drives ackN low for exactly ACK_CYCLES enabled bus cycles (default 1), starting at the edge that samples the read.
- R6: A capture while ready is 1 and no data read is taking place overwrites rxData and sets rxStatus bit 1 (overrun).
- R7: A status read (rdStatus high on an enabled edge) clears overrun and leaves rxData and ready unchanged.
- R8: On clock edges where busEn is low, strobes and reads have no effect, and no output changes.
- R9: irqN is low exactly while ready is 1.
- R10: When a capture and a data read fall on the same enabled edge, the new byte is kept, ready stays 1, overrun is not set, and the acknowledge pulse is still produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busEn | input | 1 | Bus-cycle enable; state advances only when high |
| keyData | input | DATA_W | Parallel character from the source, positive logic |
| keyStrobeN | input | 1 | Active-low data strobe from the source |
| rdData | input | 1 | Processor read of the data port |
| rdStatus | input | 1 | Processor read of the status port |
| irqN | output | 1 | Active-low interrupt request |
| ackN | output | 1 | Active-low acknowledge toward the source |
| rxData | output | DATA_W | Data port contents |
| rxStatus | output | DATA_W | Status port: bit 0 ready, bit 1 overrun, rest zero |

## Verification
A strobe fall passes through the two synchronizer flops and the edge detector. The captured byte, ready and irqN therefore appear after the third enabled rising edge, and the bench samples them at the falling clock edge that follows. Read effects take a single edge: ready, irqN, overrun and ackN change on the edge that samples the read. The bench checks ackN low at the next falling edge and high again one cycle later. The coincident read-and-capture case is set up by raising rdData just before the third edge after the strobe fall. Stimulus changes only on falling clock edges, so every sample falls a half period away from any register update.

// File: rtl/kbd_port_pkg.sv
package kbd_port_pkg;
  // Status bit positions decoded by software
  localparam int READY_BIT   = 0;
  localparam int OVERRUN_BIT = 1;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadByte;
  } dpCtl_t;
endpackage

// File: rtl/kbd_strobe_sync.sv
module kbd_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  chain[i] <= 1'b1;
        else if (en) chain[i] <= din;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  chain[i] <= 1'b1;
        else if (en) chain[i] <= chain[i-1];
      end
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/kbd_port_ctrl.sv
module kbd_port_ctrl
  import kbd_port_pkg::*;
#(
  parameter int ACK_CYCLES = 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   busEn,
  input  logic   strobeSync,
  input  logic   rdData,
  input  logic   rdStatus,
  output dpCtl_t ctl,
  output logic   irqN,
  output logic   ackN,
  output logic   dataReady,
  output logic   overrun
);
  localparam int CNT_W = $clog2(ACK_CYCLES + 1);

  logic             strobePrev;
  logic             takeByte;
  logic             readNow;
  logic             statNow;
  logic [CNT_W-1:0] ackCnt;

  assign takeByte = busEn & strobePrev & ~strobeSync;
  assign readNow  = busEn & rdData;
  assign statNow  = busEn & rdStatus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     strobePrev <= 1'b1;
    else if (busEn) strobePrev <= strobeSync;
  end

  // Ready flag; capture has priority over a coincident read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dataReady <= 1'b0;
    else if (takeByte) dataReady <= 1'b1;
    else if (readNow)  dataReady <= 1'b0;
  end

  // Interrupt kept in its own register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irqN <= 1'b1;
    else if (takeByte) irqN <= 1'b0;
    else if (readNow)  irqN <= 1'b1;
  end

  // Sticky overrun; a new loss wins over a status clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  overrun <= 1'b0;
    else if (takeByte && dataReady && !readNow)  overrun <= 1'b1;
    else if (statNow)                            overrun <= 1'b0;
  end

  // Acknowledge length counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ackCnt <= '0;
    else if (readNow)              ackCnt <= CNT_W'(ACK_CYCLES);
    else if (busEn && ackCnt != 0) ackCnt <= ackCnt - 1'b1;
  end

  assign ackN         = (ackCnt == '0);
  assign ctl.loadByte = takeByte;

  p_irq_matches_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irqN == !dataReady);
  p_read_releases_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (readNow && !takeByte) |=> (irqN && !dataReady));
  p_ack_starts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    readNow |=> !ackN);
  p_overrun_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (takeByte && dataReady && !readNow) |=> overrun);
  p_coincide_no_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (takeByte && readNow && !overrun) |=> (!overrun && dataReady));
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busEn |=> ($stable(irqN) && $stable(ackN) && $stable(overrun)));
endmodule

// File: rtl/kbd_port_dp.sv
module kbd_port_dp
  import kbd_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] keyData,
  input  logic              dataReady,
  input  logic              overrun,
  output logic [DATA_W-1:0] rxData,
  output logic [DATA_W-1:0] rxStatus
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rxData <= '0;
    else if (ctl.loadByte) rxData <= keyData;
  end

  always_comb begin
    rxStatus              = '0;
    rxStatus[READY_BIT]   = dataReady;
    rxStatus[OVERRUN_BIT] = overrun;
  end

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.loadByte |=> (rxData == $past(keyData)));
  p_hold_without_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.loadByte |=> $stable(rxData));
endmodule

// File: rtl/kbd_strobe_port.sv
module kbd_strobe_port
  import kbd_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ACK_CYCLES  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busEn,
  input  logic [DATA_W-1:0] keyData,
  input  logic              keyStrobeN,
  input  logic              rdData,
  input  logic              rdStatus,
  output logic              irqN,
  output logic              ackN,
  output logic [DATA_W-1:0] rxData,
  output logic [DATA_W-1:0] rxStatus
);
  logic   strobeSync;
  logic   dataReady;
  logic   overrun;
  dpCtl_t ctl;

  kbd_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .en(busEn), .din(keyStrobeN), .dout(strobeSync)
  );

  kbd_port_ctrl #(.ACK_CYCLES(ACK_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .busEn(busEn), .strobeSync(strobeSync),
    .rdData(rdData), .rdStatus(rdStatus), .ctl(ctl), .irqN(irqN),
    .ackN(ackN), .dataReady(dataReady), .overrun(overrun)
  );

  kbd_port_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .keyData(keyData),
    .dataReady(dataReady), .overrun(overrun), .rxData(rxData), .rxStatus(rxStatus)
  );
endmodule

// File: tb/sim_kbd_strobe_port.sv
module sim_kbd_strobe_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       busEn = 1'b1;
  logic [7:0] keyData = 8'h00;
  logic       keyStrobeN = 1'b1;
  logic       rdData = 1'b0;
  logic       rdStatus = 1'b0;
  logic       irqN, ackN;
  logic [7:0] rxData, rxStatus;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;
  bit  modelReady = 1'b0;
  bit  modelOv = 1'b0;

  always #5 clk = ~clk;

  kbd_strobe_port u0 (
    .clk(clk), .rst_n(rst_n), .busEn(busEn), .keyData(keyData),
    .keyStrobeN(keyStrobeN), .rdData(rdData), .rdStatus(rdStatus),
    .irqN(irqN), .ackN(ackN), .rxData(rxData), .rxStatus(rxStatus)
  );

  // {byte, read after capture}
  localparam logic [8:0] VEC [0:5] = '{
    {8'h41, 1'b1}, {8'h5A, 1'b0}, {8'h30, 1'b1},
    {8'hFF, 1'b0}, {8'h00, 1'b0}, {8'h7E, 1'b1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); keyData = b; keyStrobeN = 1'b0;
    repeat (3) @(negedge clk);
    keyStrobeN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic readByte(input string tag);
    rdData = 1'b1;
    @(negedge clk); rdData = 1'b0;
    chk({tag, " ackN low"}, ackN, 0);
    chk({tag, " irqN released"}, irqN, 1);
    @(negedge clk);
    chk({tag, " ackN one cycle"}, ackN, 1);
  endtask

  task automatic readStat();
    rdStatus = 1'b1;
    @(negedge clk); rdStatus = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irqN", irqN, 1);
    chk("R1 ackN", ackN, 1);
    chk("R1 rxData", rxData, 0);
    chk("R1 rxStatus", rxStatus, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 exact capture timing
    @(negedge clk); keyData = 8'h3C; keyStrobeN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 not yet after two edges", irqN, 1);
    @(negedge clk);
    chk("R2 rxData third edge", rxData, 8'h3C);
    chk("R2 irqN low", irqN, 0);
    keyStrobeN = 1'b1;
    repeat (3) @(negedge clk);
    readByte("R4 R5 first");
    chk("R4 ready cleared", rxStatus, 0);
    modelReady = 0;

    // Vector table: R2 R6 R7 R9
    foreach (VEC[i]) begin
      automatic logic [7:0] b = VEC[i][8:1];
      automatic bit expOv = modelOv | modelReady;
      sendByte(b);
      modelReady = 1; modelOv = expOv;
      chk("R2 vec data", rxData, b);
      chk("R6 vec status", rxStatus, {6'b0, modelOv, 1'b1});
      chk("R9 vec irqN", irqN, 0);
      if (VEC[i][0]) begin
        readByte("R5 vec");
        modelReady = 0;
        chk("R4 vec ready", rxStatus[0], 0);
      end
      if (modelOv) begin
        readStat();
        modelOv = 0;
        chk("R7 overrun cleared", rxStatus[1], 0);
        chk("R7 data kept", rxData, b);
        chk("R7 ready kept", rxStatus[0], modelReady);
      end
    end
    if (modelReady) begin readByte("R5 drain"); modelReady = 0; end

    // R3 held-low strobe captures once
    @(negedge clk); keyData = 8'hA5; keyStrobeN = 1'b0;
    repeat (3) @(negedge clk);
    readByte("R3 read");
    keyData = 8'h5A;
    repeat (6) @(negedge clk);
    chk("R3 ready stays clear", rxStatus[0], 0);
    chk("R3 data unchanged", rxData, 8'hA5);
    keyStrobeN = 1'b1;
    repeat (3) @(negedge clk);

    // R8 no effect while busEn low
    sendByte(8'h11);
    busEn = 1'b0;
    keyData = 8'h22; keyStrobeN = 1'b0; rdData = 1'b1; rdStatus = 1'b1;
    repeat (5) @(negedge clk);
    keyStrobeN = 1'b1; rdData = 1'b0; rdStatus = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 irqN held", irqN, 0);
    chk("R8 ackN held", ackN, 1);
    chk("R8 data held", rxData, 8'h11);
    busEn = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 no late capture", rxData, 8'h11);
    chk("R8 status after", rxStatus, 8'h01);

    // R10 read coincides with capture
    @(negedge clk); keyData = 8'h66; keyStrobeN = 1'b0;
    repeat (2) @(negedge clk);
    rdData = 1'b1;
    @(negedge clk); rdData = 1'b0;
    chk("R10 new byte", rxData, 8'h66);
    chk("R10 ready kept no overrun", rxStatus, 8'h01);
    chk("R10 ackN low", ackN, 0);
    chk("R10 irqN low", irqN, 0);
    keyStrobeN = 1'b1;
    repeat (3) @(negedge clk);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule